// File: doc/BRIEF.md
# Polynomial Temperature Gain Compensator

This block turns a signed temperature deviation into three gain-adjust words. Each of the three measurement channels has one. The channels are: channel 0 for the voltage inputs, channel 1 for the first current input and channel 2 for the second current input. Each channel holds a linear and a quadratic coefficient. The block evaluates a fixed-point quadratic in the deviation. The quadratic adds a linear term scaled down by 2^14 and a squared term scaled down by 2^23 to a base of 16385. The base is the near-unity gain word that results when compensation is off.

The deviation is given in steps of 0.1 degree from the calibration point. For example, with calibration at 22 degrees, a reading of 27 degrees gives a deviation of 50. Software loads coefficients through a small write port. A single start pulse latches the deviation. The block then works through the channels in order with one shared multiplier. Each result is placed on its own output register and also presented on a write strobe at one of three consecutive addresses. A one-cycle done pulse ends the computation.

Top module: `tcomp_gain_top`

## Requirements
- R1: After reset, all three gain outputs read 16385, and busy_o, done_o and res_we_o are all 0.
- R2: The deviation and the coefficients are 16-bit two's complement. Each result equals 16385 + floor(T*L / 2^14) + floor(T*T*Q / 2^23), where T is the latched deviation and L and Q are the channel's linear and quadratic coefficients. Both products are kept at full width, and both shifts round toward negative infinity, so T=-3 with L=1, Q=0 gives 16384.
- R3: A channel whose two coefficients are both zero produces exactly 16385, whatever the deviation.
- R4: The sum saturates to the unsigned 16-bit range. A negative sum gives 0, a sum above 65535 gives 65535, and the result never wraps.
- R5: Results appear in channel order 0, 1, 2. Channel c is written at address 0x40+c with a one-cycle res_we_o strobe, and the same value appears on gainc_o.
- R6: If start_i is sampled at clock edge k, the write for channel c is visible after edge k+4+3c. A single-cycle done_o pulse is visible after edge k+11.
- R7: busy_o is high from the edge after a start until the done pulse. A start_i sampled while busy_o is high is ignored.
- R8: A coefficient write is taken only while busy_o is low. cfg_chan_i selects the channel (0 to 2), and cfg_sel_i selects the coefficient: 0 for linear, 1 for quadratic. A write to channel 3, or any write while busy_o is high, has no effect.
- R9: The deviation is latched at start. Changes on temp_i during a computation do not affect its results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, latches temp_i |
| temp_i | input | 16 | Signed temperature deviation, 0.1 degree steps |
| cfg_we_i | input | 1 | Coefficient write strobe |
| cfg_chan_i | input | 2 | Coefficient channel select |
| cfg_sel_i | input | 1 | 0 selects the linear coefficient, 1 selects the quadratic coefficient |
| cfg_data_i | input | 16 | Signed coefficient value |
| busy_o | output | 1 | Computation in progress |
| done_o | output | 1 | One-cycle completion pulse |
| gain0_o | output | 16 | Channel 0 (voltage) gain word |
| gain1_o | output | 16 | Channel 1 (first current) gain word |
| gain2_o | output | 16 | Channel 2 (second current) gain word |
| res_we_o | output | 1 | Result write strobe |
| res_addr_o | output | 8 | Result address, 0x40 to 0x42 |
| res_data_o | output | 16 | Result data |

## Verification
The three result writes are due 4, 7 and 10 edges after the edge that samples start, and the done pulse is due 11 edges after it. The bench records the edge count at the start. It gives each expected write its due count, and gives the done pulse its own due count. The monitor checks every strobe against the head of the queue, including the count on which the strobe appeared. It then checks the gain registers once done has been seen.

// File: rtl/tcomp_pkg.sv
package tcomp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SQ,
        ST_LIN,
        ST_QUAD,
        ST_WR,
        ST_DONE
    } tc_state_e;
endpackage

// File: rtl/tcomp_mul.sv
module tcomp_mul #(
    parameter int A_W = 32,
    parameter int B_W = 16
) (
    input  logic signed [A_W-1:0]     a_i,
    input  logic signed [B_W-1:0]     b_i,
    output logic signed [A_W+B_W-1:0] p_o
);
    localparam int P_W = A_W + B_W;

    assign p_o = P_W'(a_i) * P_W'(b_i);
endmodule

// File: rtl/tcomp_coef_bank.sv
module tcomp_coef_bank #(
    parameter int NUM_CH = 3,
    parameter int DATA_W = 16,
    parameter int CH_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic              busy_i,
    input  logic [CH_W-1:0]   chan_i,
    input  logic              sel_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [CH_W-1:0]   rd_chan_i,
    output logic [DATA_W-1:0] lin_o,
    output logic [DATA_W-1:0] quad_o
);
    typedef struct packed {
        logic [NUM_CH-1:0][DATA_W-1:0] lin;
        logic [NUM_CH-1:0][DATA_W-1:0] quad;
    } bank_t;

    bank_t bank_d, bank_q;
    logic [NUM_CH-1:0] wr_lin, wr_quad;
    logic take;

    assign take = we_i && !busy_i;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_dec
        assign wr_lin[g]  = take && (chan_i == CH_W'(g)) && !sel_i;
        assign wr_quad[g] = take && (chan_i == CH_W'(g)) &&  sel_i;
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NUM_CH; i++) begin
            if (wr_lin[i])  bank_d.lin[i]  = data_i;
            if (wr_quad[i]) bank_d.quad[i] = data_i;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    always_comb begin
        lin_o  = '0;
        quad_o = '0;
        if (rd_chan_i < CH_W'(NUM_CH)) begin
            lin_o  = bank_q.lin[rd_chan_i];
            quad_o = bank_q.quad[rd_chan_i];
        end
    end

    AST_COEF_FROZEN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |=> $stable(bank_q)); // R8
endmodule

// File: rtl/tcomp_engine.sv
module tcomp_engine
    import tcomp_pkg::*;
#(
    parameter int NUM_CH     = 3,
    parameter int DATA_W     = 16,
    parameter int CH_W       = 2,
    parameter int ADDR_W     = 8,
    parameter int BASE_ADDR  = 'h40,
    parameter int BASE       = 16385,
    parameter int LIN_SHIFT  = 14,
    parameter int QUAD_SHIFT = 23
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start_i,
    input  logic [DATA_W-1:0]             temp_i,
    input  logic [DATA_W-1:0]             lin_i,
    input  logic [DATA_W-1:0]             quad_i,
    output logic [CH_W-1:0]               rd_chan_o,
    output logic                          busy_o,
    output logic                          done_o,
    output logic [NUM_CH-1:0][DATA_W-1:0] gain_o,
    output logic                          res_we_o,
    output logic [ADDR_W-1:0]             res_addr_o,
    output logic [DATA_W-1:0]             res_data_o
);
    localparam int SQ_W   = 2 * DATA_W;
    localparam int PROD_W = SQ_W + DATA_W;
    localparam int ACC_W  = PROD_W;
    localparam logic [ADDR_W-1:0] FIRST_ADDR = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] LAST_ADDR  = ADDR_W'(BASE_ADDR + NUM_CH - 1);

    typedef struct packed {
        tc_state_e                     st;
        logic [CH_W-1:0]               ch;
        logic signed [DATA_W-1:0]      temp;
        logic signed [SQ_W-1:0]        sq;
        logic signed [ACC_W-1:0]       acc;
        logic [NUM_CH-1:0][DATA_W-1:0] gain;
        logic                          we;
        logic [ADDR_W-1:0]             addr;
        logic [DATA_W-1:0]             data;
        logic                          done;
    } eng_t;

    eng_t eng_d, eng_q;

    logic signed [SQ_W-1:0]   mul_a;
    logic signed [DATA_W-1:0] mul_b;
    logic signed [PROD_W-1:0] prod;
    logic signed [ACC_W-1:0]  lin_term, quad_term, sum_v;
    logic [DATA_W-1:0]        sat_v;

    always_comb begin
        mul_a = '0;
        mul_b = '0;
        unique case (eng_q.st)
            ST_SQ: begin
                mul_a = {{DATA_W{eng_q.temp[DATA_W-1]}}, eng_q.temp};
                mul_b = eng_q.temp;
            end
            ST_LIN: begin
                mul_a = {{DATA_W{eng_q.temp[DATA_W-1]}}, eng_q.temp};
                mul_b = lin_i;
            end
            ST_QUAD: begin
                mul_a = eng_q.sq;
                mul_b = quad_i;
            end
            default: ;
        endcase
    end

    tcomp_mul #(.A_W(SQ_W), .B_W(DATA_W)) mul_i (
        .a_i (mul_a),
        .b_i (mul_b),
        .p_o (prod)
    );

    assign lin_term  = prod >>> LIN_SHIFT;
    assign quad_term = prod >>> QUAD_SHIFT;
    assign sum_v     = eng_q.acc + ACC_W'(BASE);

    always_comb begin
        if (sum_v < 0)                        sat_v = '0;
        else if (sum_v[ACC_W-1:DATA_W] != '0) sat_v = '1;
        else                                  sat_v = sum_v[DATA_W-1:0];
    end

    always_comb begin
        eng_d      = eng_q;
        eng_d.we   = 1'b0;
        eng_d.done = 1'b0;
        unique case (eng_q.st)
            ST_IDLE: if (start_i) begin
                eng_d.temp = temp_i;
                eng_d.ch   = '0;
                eng_d.st   = ST_SQ;
            end
            ST_SQ: begin
                eng_d.sq = prod[SQ_W-1:0];
                eng_d.st = ST_LIN;
            end
            ST_LIN: begin
                eng_d.acc = lin_term;
                eng_d.st  = ST_QUAD;
            end
            ST_QUAD: begin
                eng_d.acc = eng_q.acc + quad_term;
                eng_d.st  = ST_WR;
            end
            ST_WR: begin
                eng_d.gain[eng_q.ch] = sat_v;
                eng_d.we             = 1'b1;
                eng_d.addr           = FIRST_ADDR + ADDR_W'(eng_q.ch);
                eng_d.data           = sat_v;
                if (eng_q.ch == CH_W'(NUM_CH - 1)) begin
                    eng_d.st = ST_DONE;
                end else begin
                    eng_d.ch = eng_q.ch + 1'b1;
                    eng_d.st = ST_LIN;
                end
            end
            ST_DONE: begin
                eng_d.done = 1'b1;
                eng_d.st   = ST_IDLE;
            end
            default: eng_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_q      <= '0;
            eng_q.gain <= {NUM_CH{DATA_W'(BASE)}};
        end else begin
            eng_q <= eng_d;
        end
    end

    assign rd_chan_o  = eng_q.ch;
    assign busy_o     = (eng_q.st != ST_IDLE);
    assign done_o     = eng_q.done;
    assign gain_o     = eng_q.gain;
    assign res_we_o   = eng_q.we;
    assign res_addr_o = eng_q.addr;
    assign res_data_o = eng_q.data;

    AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R7
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R6
    AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(res_we_o) && $past(res_addr_o) == LAST_ADDR)); // R6
    AST_WRITE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (res_we_o && res_addr_o != FIRST_ADDR) |->
            ($past(res_we_o, 3) && $past(res_addr_o, 3) == res_addr_o - ADDR_W'(1))); // R5
    AST_TEMP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> $stable(eng_q.temp)); // R9
endmodule

// File: rtl/tcomp_gain_top.sv
module tcomp_gain_top #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] temp_i,
    input  logic              cfg_we_i,
    input  logic [1:0]        cfg_chan_i,
    input  logic              cfg_sel_i,
    input  logic [DATA_W-1:0] cfg_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] gain0_o,
    output logic [DATA_W-1:0] gain1_o,
    output logic [DATA_W-1:0] gain2_o,
    output logic              res_we_o,
    output logic [ADDR_W-1:0] res_addr_o,
    output logic [DATA_W-1:0] res_data_o
);
    localparam int NUM_CH = 3;
    localparam int CH_W   = 2;

    logic [CH_W-1:0]               rd_chan;
    logic [DATA_W-1:0]             lin_c, quad_c;
    logic [NUM_CH-1:0][DATA_W-1:0] gains;

    tcomp_coef_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W), .CH_W(CH_W)) bank_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .we_i      (cfg_we_i),
        .busy_i    (busy_o),
        .chan_i    (cfg_chan_i),
        .sel_i     (cfg_sel_i),
        .data_i    (cfg_data_i),
        .rd_chan_i (rd_chan),
        .lin_o     (lin_c),
        .quad_o    (quad_c)
    );

    tcomp_engine #(
        .NUM_CH (NUM_CH),
        .DATA_W (DATA_W),
        .CH_W   (CH_W),
        .ADDR_W (ADDR_W)
    ) eng_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start_i),
        .temp_i     (temp_i),
        .lin_i      (lin_c),
        .quad_i     (quad_c),
        .rd_chan_o  (rd_chan),
        .busy_o     (busy_o),
        .done_o     (done_o),
        .gain_o     (gains),
        .res_we_o   (res_we_o),
        .res_addr_o (res_addr_o),
        .res_data_o (res_data_o)
    );

    assign gain0_o = gains[0];
    assign gain1_o = gains[1];
    assign gain2_o = gains[2];
endmodule

// File: tb/tcomp_gain_top_tb_top.sv
`timescale 1ns/1ps
module tcomp_gain_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] temp_i = '0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_chan_i = '0;
    logic        cfg_sel_i = 1'b0;
    logic [15:0] cfg_data_i = '0;
    logic        busy_o, done_o, res_we_o;
    logic [15:0] gain0_o, gain1_o, gain2_o, res_data_o;
    logic [7:0]  res_addr_o;

    always #5 clk = ~clk;

    tcomp_gain_top dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .temp_i(temp_i),
        .cfg_we_i(cfg_we_i), .cfg_chan_i(cfg_chan_i), .cfg_sel_i(cfg_sel_i),
        .cfg_data_i(cfg_data_i), .busy_o(busy_o), .done_o(done_o),
        .gain0_o(gain0_o), .gain1_o(gain1_o), .gain2_o(gain2_o),
        .res_we_o(res_we_o), .res_addr_o(res_addr_o), .res_data_o(res_data_o)
    );

    typedef struct {
        logic [7:0]  addr;
        logic [15:0] data;
        int          due;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   fails = 0;
    int   cyc = 0;
    int   done_due = -1;
    int   m_lin[3];
    int   m_quad[3];
    logic [15:0] last_exp[3];
    bit   finished = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic logic [15:0] model(input int t, input int l, input int q);
        longint lt, qt, s;
        lt = (longint'(t) * longint'(l)) >>> 14;
        qt = ((longint'(t) * longint'(t)) * longint'(q)) >>> 23;
        s  = 64'sd16385 + lt + qt;
        if (s < 0) return 16'd0;
        if (s > 65535) return 16'hFFFF;
        return s[15:0];
    endfunction

    // Driver: pushes expectations, pulses start, then scrambles temp_i (R9)
    task automatic start_calc(input int t);
        @(negedge clk);
        for (int c = 0; c < 3; c++) begin
            exp_t e;
            e.addr = 8'h40 + 8'(c);
            e.data = model(t, m_lin[c], m_quad[c]);
            e.due  = cyc + 1 + 4 + 3 * c;
            last_exp[c] = e.data;
            exp_q.push_back(e);
        end
        done_due = cyc + 1 + 11;
        start_i  = 1'b1;
        temp_i   = 16'(t);
        @(negedge clk);
        start_i  = 1'b0;
        temp_i   = ~16'(t);
    endtask

    task automatic finish_calc();
        repeat (12) @(negedge clk);
        check(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);
        check(gain0_o == last_exp[0], "R5 gain0_o", gain0_o, last_exp[0]);
        check(gain1_o == last_exp[1], "R5 gain1_o", gain1_o, last_exp[1]);
        check(gain2_o == last_exp[2], "R5 gain2_o", gain2_o, last_exp[2]);
        check(!busy_o, "R7 busy low after done", busy_o, 0);
    endtask

    task automatic run_calc(input int t);
        start_calc(t);
        finish_calc();
    endtask

    task automatic write_coef(input int ch, input bit sel, input int val, input bit taken);
        @(negedge clk);
        cfg_we_i   = 1'b1;
        cfg_chan_i = 2'(ch);
        cfg_sel_i  = sel;
        cfg_data_i = 16'(val);
        @(negedge clk);
        cfg_we_i   = 1'b0;
        if (taken && ch < 3) begin
            if (sel) m_quad[ch] = val;
            else     m_lin[ch]  = val;
        end
    endtask

    // Monitor: scoreboard comparison on every write strobe and done pulse (R5, R6)
    always @(negedge clk) begin
        if (rst_n && res_we_o) begin
            if (exp_q.size() == 0) begin
                check(0, "R5 unexpected write", res_addr_o, 0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                check(res_addr_o == e.addr, "R5 write address", res_addr_o, e.addr);
                check(res_data_o == e.data, "R2 write data", res_data_o, e.data);
                check(cyc == e.due, "R6 write cycle", cyc, e.due);
            end
        end
        if (rst_n && done_o) begin
            check(cyc == done_due, "R6 done cycle", cyc, done_due);
        end
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        for (int c = 0; c < 3; c++) begin
            m_lin[c] = 0;
            m_quad[c] = 0;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(gain0_o == 16'd16385, "R1 gain0 reset", gain0_o, 16385);
        check(gain1_o == 16'd16385, "R1 gain1 reset", gain1_o, 16385);
        check(gain2_o == 16'd16385, "R1 gain2 reset", gain2_o, 16385);
        check(!busy_o && !done_o && !res_we_o, "R1 control reset",
              {busy_o, done_o, res_we_o}, 0);

        // R3 zero coefficients give base
        run_calc(50);
        check(gain1_o == 16'd16385, "R3 zero coef", gain1_o, 16385);

        // R2 floor rounding of negative product
        write_coef(0, 1'b0, 1, 1'b1);
        run_calc(-3);
        check(gain0_o == 16'd16384, "R2 floor shift", gain0_o, 16384);

        // R4 saturation both ways, R8 quadratic select
        write_coef(0, 1'b0, 1000, 1'b1);
        write_coef(0, 1'b1, -500, 1'b1);
        write_coef(1, 1'b0, -32768, 1'b1);
        write_coef(2, 1'b0, 32767, 1'b1);
        write_coef(2, 1'b1, 32767, 1'b1);
        run_calc(32767);
        check(gain1_o == 16'd0, "R4 saturate low", gain1_o, 0);
        check(gain2_o == 16'hFFFF, "R4 saturate high", gain2_o, 65535);

        // R2 several deviations
        run_calc(-300);
        run_calc(50);
        run_calc(250);
        run_calc(-32768);

        // R7, R8: start and coefficient write while busy are ignored
        start_calc(120);
        check(busy_o, "R7 busy during run", busy_o, 1);
        write_coef(1, 1'b0, 5, 1'b0);
        @(negedge clk);
        start_i = 1'b1;
        temp_i  = 16'd7;
        @(negedge clk);
        start_i = 1'b0;
        repeat (9) @(negedge clk);
        check(exp_q.size() == 0, "R7 run complete", exp_q.size(), 0);
        check(!busy_o, "R7 busy low after ignored start", busy_o, 0);
        run_calc(120);

        // R8 write to channel 3 is ignored
        write_coef(3, 1'b0, 12345, 1'b0);
        run_calc(-77);

        // R9 temp latched (start_calc scrambles temp_i during each run)
        write_coef(1, 1'b1, 20000, 1'b1);
        run_calc(400);
        check(gain1_o == model(400, m_lin[1], m_quad[1]), "R9 latched temp",
              gain1_o, model(400, m_lin[1], m_quad[1]));

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule